// File: doc/BRIEF.md
# Clean-Owner Directory Request Router

This block is the central directory for a small multi-core chip whose cores each own a private cache. For every block it tracks, it keeps a bit-vector of the cores that hold a clean copy. A read miss is served from a peer cache whenever any other core holds the block, and goes to memory only when no core does. The directory also follows how many copies of each block remain on chip. When a single copy is left, it tells the core that holds it that the copy is a singlet. When a singlet gains a second holder, it tells the former holder that the copy is no longer a singlet.

Cores send three kinds of request over one request port: read misses, clean-replacement notices, and spill requests. A spill moves an evicted block into a peer cache in two steps: the evicting core sends the request to the directory, and the directory forwards it to the recipient. Commands leave on one command port, one per cycle. The directory handles one request at a time. Tracked blocks live in a small fully associative table. An entry is released when its holder set becomes empty.

Top module: `clean_owner_router`

## Requirements
- R1: A request is accepted on a clock edge where reqValid and reqReady are both high. Call that edge A. reqReady is high when the block is idle and low in the cycle after acceptance. It returns high after edge A+1 when the request issues no notice and does not wait for memory, and after edge A+2 when it issues a notice.
- R2: A read whose block is held by at least one core other than the requester issues a forward command at edge A+1. The forward goes to the lowest-numbered such holder, and the requester is added to the holder set.
- R3: A read whose block has no holder other than the requester issues a memory-read command to the requester at edge A+1. reqReady then stays low until fillValid is sampled high. A fillValid pulse while no memory read is outstanding has no effect.
- R4: An update that leaves a tracked block with exactly one holder, where the holder set before the update was different, issues a singlet command to that holder. After the fill of a tracked block, the requester becomes its only holder. The notice is registered at edge A+2, or at edge F+1 when the fill is sampled at edge F.
- R5: An update that takes a block from exactly one holder to more than one issues a no-longer-singlet command to the former holder at edge A+2.
- R6: A clean-replacement notice removes the requesting core from the block's holder set and issues no primary command. A notice from a core that is not a holder, or for an untracked block, changes nothing and issues no command.
- R7: A spill issues a spill-forward command to the recipient (reqDest) at edge A+1. For a tracked block, the evicting core is removed from the holder set and the recipient is added to it.
- R8: The table holds ENTRIES blocks, and an entry is released when its holder set becomes empty. A read of an untracked block takes the lowest free entry at fill time. When no entry is free, the read is still served from memory, but the block stays untracked and no singlet notice follows.
- R9: Encodings. reqKind: 0 read, 1 clean replacement, 2 spill. cmdKind: 1 forward, 2 memory read, 3 spill-forward, 4 singlet, 5 no-longer-singlet. cmdSrc is the core whose request caused the command, and cmdAddr is that request's block address. cmdKind is meaningful only while cmdValid is high.
- R10: After reset, reqReady is high, cmdValid is low and the table is empty. The block never raises cmdValid except as required above.
- R11: reqKind 3 is a no-op. It issues no command, changes no holder set, and holds reqReady low for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Directory idle, request may be accepted |
| reqKind | input | 2 | Request kind (R9) |
| reqCore | input | CORE_W | Requesting core (for a spill, the evicting core) |
| reqDest | input | CORE_W | Spill recipient core |
| reqAddr | input | ADDR_W | Block address |
| fillValid | input | 1 | Memory read data has arrived |
| cmdValid | output | 1 | Command valid for one cycle |
| cmdKind | output | 3 | Command kind (R9) |
| cmdCore | output | CORE_W | Target core of the command |
| cmdSrc | output | CORE_W | Core whose request caused the command |
| cmdAddr | output | ADDR_W | Block address of the command |

## Verification
Counting the acceptance edge as A, a primary command (forward, memory read, spill-forward) is due in the cycle after edge A+1. A singlet or no-longer-singlet notice is due one edge later, and a notice after a fill is due after edge F+1, where F is the edge that samples fillValid. The bench's reference model stamps each expected command with its due edge number and keeps them in a queue. On every falling edge it compares the command port with the head of the queue when the head is due, and otherwise requires cmdValid low. reqReady is compared on every falling edge against the model's own busy window, so early or late commands and early or late release of the request port both show up in the cycle where they happen.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  typedef enum logic [1:0] {
    RK_READ  = 2'd0,
    RK_PUTS  = 2'd1,
    RK_SPILL = 2'd2,
    RK_NOP   = 2'd3
  } reqKind_e;

  typedef enum logic [2:0] {
    CK_IDLE      = 3'd0,
    CK_FWD       = 3'd1,
    CK_MEMRD     = 3'd2,
    CK_SPILLFWD  = 3'd3,
    CK_SINGLET   = 3'd4,
    CK_UNSINGLET = 3'd5
  } cmdKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic doExec;
    logic doFill;
    logic emitNote;
  } ctrlStrobe_t;

endpackage

// File: rtl/ccr_table.sv
module ccr_table #(
  parameter int NUM_CORES = 4,
  parameter int ENTRIES   = 16,
  parameter int ADDR_W    = 16,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    lkAddr,
  input  logic                 wrEn,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [NUM_CORES-1:0] wrShr,
  output logic                 hit,
  output logic [IDX_W-1:0]     hitIdx,
  output logic [NUM_CORES-1:0] hitShr,
  output logic                 freeOk,
  output logic [IDX_W-1:0]     freeIdx
);

  logic [ENTRIES-1:0]   entValid;
  logic [ADDR_W-1:0]    entTag [ENTRIES];
  logic [NUM_CORES-1:0] entShr [ENTRIES];
  logic [ENTRIES-1:0]   matchVec;

  // one comparator per entry
  for (genvar e = 0; e < ENTRIES; e++) begin : g_match
    assign matchVec[e] = entValid[e] && (entTag[e] == lkAddr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        entTag[e] <= '0;
        entShr[e] <= '0;
      end
    end else if (wrEn) begin
      entValid[wrIdx] <= |wrShr;   // empty holder set releases the entry
      entTag[wrIdx]   <= wrAddr;
      entShr[wrIdx]   <= wrShr;
    end
  end

  always_comb begin
    hit     = 1'b0;
    hitIdx  = '0;
    hitShr  = '0;
    freeOk  = 1'b0;
    freeIdx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!hit && matchVec[e]) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(e);
        hitShr = entShr[e];
      end
      if (!freeOk && !entValid[e]) begin
        freeOk  = 1'b1;
        freeIdx = IDX_W'(e);
      end
    end
  end

endmodule

// File: rtl/ccr_datapath.sv
module ccr_datapath
  import ccr_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ENTRIES   = 16,
  parameter int ADDR_W    = 16,
  localparam int CORE_W   = $clog2(NUM_CORES),
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [1:0]        reqKind,
  input  logic [CORE_W-1:0] reqCore,
  input  logic [CORE_W-1:0] reqDest,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              needMem,
  output logic              execNote,
  output logic              fillNote,
  output logic              cmdValid,
  output logic [2:0]        cmdKind,
  output logic [CORE_W-1:0] cmdCore,
  output logic [CORE_W-1:0] cmdSrc,
  output logic [ADDR_W-1:0] cmdAddr
);

  function automatic logic [CORE_W-1:0] lowestOf(input logic [NUM_CORES-1:0] v);
    logic [CORE_W-1:0] idx;
    idx = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (v[i]) idx = CORE_W'(i);
    end
    return idx;
  endfunction

  function automatic cmdKind_e noteKindOf(input logic [NUM_CORES-1:0] oldV,
                                          input logic [NUM_CORES-1:0] newV);
    cmdKind_e k;
    k = CK_IDLE;
    if ($countones(oldV) == 1 && $countones(newV) > 1) k = CK_UNSINGLET;
    else if ($countones(newV) == 1 && oldV != newV)    k = CK_SINGLET;
    return k;
  endfunction

  // latched request
  reqKind_e          rKind;
  logic [CORE_W-1:0] rCore, rDest;
  logic [ADDR_W-1:0] rAddr;

  // table interface
  logic                 hit, freeOk, wrEn;
  logic [IDX_W-1:0]     hitIdx, freeIdx, wrIdx;
  logic [NUM_CORES-1:0] hitShr, wrShr;

  // pending fill slot
  logic                 slotOk;
  logic [IDX_W-1:0]     slotIdx;
  logic [NUM_CORES-1:0] slotOld;

  // pending notice
  cmdKind_e          noteKind;
  logic [CORE_W-1:0] noteCore;

  // exec-cycle decisions
  logic [NUM_CORES-1:0] reqBit, destBit, others, exShr;
  logic                 exWr, memNeeded;
  cmdKind_e             primKind, exNoteKind, fillNoteKind;
  logic [CORE_W-1:0]    primCore, exNoteCore, fillNoteCore;

  cmdKind_e cmdKindR;

  ccr_table #(
    .NUM_CORES(NUM_CORES), .ENTRIES(ENTRIES), .ADDR_W(ADDR_W)
  ) u_table (
    .clk(clk), .rstN(rstN), .lkAddr(rAddr),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrAddr(rAddr), .wrShr(wrShr),
    .hit(hit), .hitIdx(hitIdx), .hitShr(hitShr),
    .freeOk(freeOk), .freeIdx(freeIdx)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rKind <= RK_NOP;
      rCore <= '0;
      rDest <= '0;
      rAddr <= '0;
    end else if (stb.latchReq) begin
      rKind <= reqKind_e'(reqKind);
      rCore <= reqCore;
      rDest <= reqDest;
      rAddr <= reqAddr;
    end
  end

  always_comb begin
    reqBit  = '0;
    destBit = '0;
    reqBit[rCore]  = 1'b1;
    destBit[rDest] = 1'b1;
    others = hitShr & ~reqBit;
  end

  always_comb begin
    primKind  = CK_IDLE;
    primCore  = rCore;
    exWr      = 1'b0;
    exShr     = hitShr;
    memNeeded = 1'b0;
    case (rKind)
      RK_READ: begin
        if (hit && (|others)) begin
          primKind = CK_FWD;
          primCore = lowestOf(others);
          exWr     = 1'b1;
          exShr    = hitShr | reqBit;
        end else begin
          primKind  = CK_MEMRD;
          memNeeded = 1'b1;
        end
      end
      RK_PUTS: begin
        if (hit) begin
          exWr  = 1'b1;
          exShr = hitShr & ~reqBit;
        end
      end
      RK_SPILL: begin
        primKind = CK_SPILLFWD;
        primCore = rDest;
        if (hit) begin
          exWr  = 1'b1;
          exShr = (hitShr & ~reqBit) | destBit;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    exNoteKind   = exWr ? noteKindOf(hitShr, exShr) : CK_IDLE;
    exNoteCore   = (exNoteKind == CK_UNSINGLET) ? lowestOf(hitShr) : lowestOf(exShr);
    fillNoteKind = slotOk ? noteKindOf(slotOld, reqBit) : CK_IDLE;
    fillNoteCore = rCore;
  end

  assign needMem  = memNeeded;
  assign execNote = (exNoteKind != CK_IDLE);
  assign fillNote = (fillNoteKind != CK_IDLE);

  assign wrEn  = (stb.doExec && exWr) || (stb.doFill && slotOk);
  assign wrIdx = stb.doFill ? slotIdx : hitIdx;
  assign wrShr = stb.doFill ? reqBit : exShr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotOk   <= 1'b0;
      slotIdx  <= '0;
      slotOld  <= '0;
      noteKind <= CK_IDLE;
      noteCore <= '0;
    end else begin
      if (stb.doExec) begin
        slotOk   <= hit || freeOk;
        slotIdx  <= hit ? hitIdx : freeIdx;
        slotOld  <= hitShr;
        noteKind <= exNoteKind;
        noteCore <= exNoteCore;
      end
      if (stb.doFill) begin
        noteKind <= fillNoteKind;
        noteCore <= fillNoteCore;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdKindR <= CK_IDLE;
      cmdCore  <= '0;
      cmdSrc   <= '0;
      cmdAddr  <= '0;
    end else begin
      cmdValid <= 1'b0;
      if (stb.doExec && primKind != CK_IDLE) begin
        cmdValid <= 1'b1;
        cmdKindR <= primKind;
        cmdCore  <= primCore;
        cmdSrc   <= rCore;
        cmdAddr  <= rAddr;
      end else if (stb.emitNote) begin
        cmdValid <= 1'b1;
        cmdKindR <= noteKind;
        cmdCore  <= noteCore;
        cmdSrc   <= rCore;
        cmdAddr  <= rAddr;
      end
    end
  end

  assign cmdKind = cmdKindR;

endmodule

// File: rtl/ccr_ctrl.sv
module ccr_ctrl
  import ccr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        fillValid,
  input  logic        needMem,
  input  logic        execNote,
  input  logic        fillNote,
  output logic        reqReady,
  output ctrlStrobe_t stb
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_WAIT = 2'd2,
    ST_NOTE = 2'd3
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stb.latchReq = 1'b1;
          stateNext    = ST_EXEC;
        end
      end
      ST_EXEC: begin
        stb.doExec = 1'b1;
        if (needMem)       stateNext = ST_WAIT;
        else if (execNote) stateNext = ST_NOTE;
        else               stateNext = ST_IDLE;
      end
      ST_WAIT: begin
        if (fillValid) begin
          stb.doFill = 1'b1;
          stateNext  = fillNote ? ST_NOTE : ST_IDLE;
        end
      end
      ST_NOTE: begin
        stb.emitNote = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);

endmodule

// File: rtl/clean_owner_router.sv
module clean_owner_router
  import ccr_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ENTRIES   = 16,
  parameter int ADDR_W    = 16,
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqKind,
  input  logic [CORE_W-1:0] reqCore,
  input  logic [CORE_W-1:0] reqDest,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              fillValid,
  output logic              cmdValid,
  output logic [2:0]        cmdKind,
  output logic [CORE_W-1:0] cmdCore,
  output logic [CORE_W-1:0] cmdSrc,
  output logic [ADDR_W-1:0] cmdAddr
);

  ctrlStrobe_t stb;
  logic        needMem, execNote, fillNote;

  ccr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .fillValid(fillValid),
    .needMem(needMem), .execNote(execNote), .fillNote(fillNote),
    .reqReady(reqReady), .stb(stb)
  );

  ccr_datapath #(
    .NUM_CORES(NUM_CORES), .ENTRIES(ENTRIES), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqKind(reqKind), .reqCore(reqCore), .reqDest(reqDest), .reqAddr(reqAddr),
    .needMem(needMem), .execNote(execNote), .fillNote(fillNote),
    .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdCore(cmdCore),
    .cmdSrc(cmdSrc), .cmdAddr(cmdAddr)
  );

endmodule

// File: rtl/ccr_checker.sv
module ccr_checker #(
  parameter int CORE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              cmdValid,
  input logic [2:0]        cmdKind,
  input logic [CORE_W-1:0] cmdCore,
  input logic [CORE_W-1:0] cmdSrc
);

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);                                   // R1

  AST_NO_CMD_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !cmdValid);                                   // R1

  AST_FWD_TO_PEER: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == 3'd1) |-> (cmdCore != cmdSrc));                  // R2

  AST_MEMRD_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == 3'd2) |-> !reqReady);                            // R3

  AST_MEMRD_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == 3'd2) |-> (cmdCore == cmdSrc));                  // R3

  AST_NOTE_RELEASES_PORT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdKind == 3'd4 || cmdKind == 3'd5)) |-> reqReady);        // R5

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdKind >= 3'd1 && cmdKind <= 3'd5));                      // R9

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && $past(reqReady) && !$past(cmdValid)) |-> !cmdValid);        // R10

endmodule

bind clean_owner_router ccr_checker #(.CORE_W(CORE_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdCore(cmdCore), .cmdSrc(cmdSrc)
);

// File: tb/clean_owner_router_bench.sv
module clean_owner_router_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NE = 16;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [1:0]    reqKind = 2'd0;
  logic [1:0]    reqCore = 2'd0;
  logic [1:0]    reqDest = 2'd0;
  logic [AW-1:0] reqAddr = '0;
  logic          fillValid = 1'b0;
  logic          cmdValid;
  logic [2:0]    cmdKind;
  logic [1:0]    cmdCore, cmdSrc;
  logic [AW-1:0] cmdAddr;

  clean_owner_router #(.NUM_CORES(NC), .ENTRIES(NE), .ADDR_W(AW)) u_clean_owner_router (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqCore(reqCore), .reqDest(reqDest), .reqAddr(reqAddr),
    .fillValid(fillValid), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdCore(cmdCore), .cmdSrc(cmdSrc), .cmdAddr(cmdAddr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int vecs = 0;
  int fails = 0;
  int cyc = 0;
  int curTag = 0;
  bit chkOn = 1'b0;
  bit finished = 1'b0;

  // ---------------- reference model ----------------
  typedef struct {
    int due; int kind; int core; int src; int addr; int tag;
  } ev_t;
  ev_t evq[$];

  bit mVal[NE];
  int mTag[NE];
  int mShr[NE];
  bit mWait = 1'b0;
  int mReadyCyc = 0;
  int pSlot, pOld, pCore, pAddr;

  function automatic int lowestBit(int v);
    for (int i = 0; i < NC; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic int ones(int v);
    int n = 0;
    for (int i = 0; i < NC; i++) if (v[i]) n++;
    return n;
  endfunction

  function automatic void pushEv(int due, int kind, int core, int src, int addr, int tag);
    ev_t e;
    e.due = due; e.kind = kind; e.core = core; e.src = src; e.addr = addr;
    e.tag = (curTag != 0) ? curTag : tag;
    evq.push_back(e);
  endfunction

  // returns 1 when a notice was scheduled
  function automatic bit noteEv(int oldV, int newV, int due, int src, int addr, int tag);
    if (ones(oldV) == 1 && ones(newV) > 1) begin
      pushEv(due, 5, lowestBit(oldV), src, addr, 5);
      return 1'b1;
    end
    if (ones(newV) == 1 && oldV != newV) begin
      pushEv(due, 4, lowestBit(newV), src, addr, tag);
      return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic int findHit(int addr);
    for (int i = 0; i < NE; i++) if (mVal[i] && mTag[i] == addr) return i;
    return -1;
  endfunction

  function automatic int findFree();
    for (int i = 0; i < NE; i++) if (!mVal[i]) return i;
    return -1;
  endfunction

  function automatic void modelAccept(int a, int kind, int core, int dest, int addr);
    int h, oldV, newV, rb, others;
    bit nt;
    h = findHit(addr);
    oldV = (h >= 0) ? mShr[h] : 0;
    rb = 1 << core;
    others = oldV & ~rb;
    nt = 1'b0;
    case (kind)
      0: begin
        if (h >= 0 && others != 0) begin
          pushEv(a + 1, 1, lowestBit(others), core, addr, 2);
          newV = oldV | rb;
          mShr[h] = newV;
          nt = noteEv(oldV, newV, a + 2, core, addr, 4);
        end else begin
          pushEv(a + 1, 2, core, core, addr, 3);
          mWait = 1'b1;
          pSlot = (h >= 0) ? h : findFree();
          pOld = oldV; pCore = core; pAddr = addr;
        end
      end
      1: begin
        if (h >= 0) begin
          newV = oldV & ~rb;
          mShr[h] = newV;
          if (newV == 0) mVal[h] = 1'b0;
          nt = noteEv(oldV, newV, a + 2, core, addr, 6);
        end
      end
      2: begin
        pushEv(a + 1, 3, dest, core, addr, 7);
        if (h >= 0) begin
          newV = (oldV & ~rb) | (1 << dest);
          mShr[h] = newV;
          nt = noteEv(oldV, newV, a + 2, core, addr, 7);
        end
      end
      default: ;
    endcase
    mReadyCyc = nt ? a + 2 : a + 1;
  endfunction

  function automatic void modelFill(int f);
    bit nt;
    nt = 1'b0;
    if (pSlot >= 0) begin
      mVal[pSlot] = 1'b1;
      mTag[pSlot] = pAddr;
      mShr[pSlot] = 1 << pCore;
      nt = noteEv(pOld, 1 << pCore, f + 1, pCore, pAddr, 4);
    end
    mWait = 1'b0;
    mReadyCyc = nt ? f + 1 : f;
  endfunction

  initial begin
    for (int i = 0; i < NE; i++) begin
      mVal[i] = 1'b0; mTag[i] = 0; mShr[i] = 0;
    end
  end

  always @(posedge clk) begin
    bit readyNow;
    cyc = cyc + 1;
    readyNow = !mWait && ((cyc - 1) >= mReadyCyc);
    if (rstN) begin
      if (reqValid && readyNow)
        modelAccept(cyc, int'(reqKind), int'(reqCore), int'(reqDest), int'(reqAddr));
      else if (fillValid && mWait)
        modelFill(cyc);
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // compare every clock
  always @(negedge clk) begin
    if (chkOn) begin
      bit expReady;
      string rt, qt;
      rt = $sformatf("R%0d ready", (curTag != 0) ? curTag : 1);
      qt = $sformatf("R%0d no command", (curTag != 0) ? curTag : 10);
      expReady = !mWait && (cyc >= mReadyCyc);
      check(reqReady == expReady, rt, int'(reqReady), int'(expReady));
      if (evq.size() > 0 && evq[0].due == cyc) begin
        ev_t e;
        string t;
        e = evq.pop_front();
        t = $sformatf("R%0d", e.tag);
        check(cmdValid == 1'b1, {t, " cmdValid"}, int'(cmdValid), 1);
        check(int'(cmdKind) == e.kind, {t, " cmdKind"}, int'(cmdKind), e.kind);
        check(int'(cmdCore) == e.core, {t, " cmdCore"}, int'(cmdCore), e.core);
        check(int'(cmdSrc) == e.src, {t, " cmdSrc"}, int'(cmdSrc), e.src);
        check(int'(cmdAddr) == e.addr, {t, " cmdAddr"}, int'(cmdAddr), e.addr);
      end else begin
        check(cmdValid == 1'b0, qt, int'(cmdValid), 0);
      end
    end
  end

  task automatic doReq(int kind, int core, int dest, int addr);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1;
    reqKind  = 2'(kind);
    reqCore  = 2'(core);
    reqDest  = 2'(dest);
    reqAddr  = AW'(addr);
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    if (mWait) begin
      repeat (2) @(negedge clk);
      fillValid = 1'b1;
      @(negedge clk);
      fillValid = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(reqReady == 1'b1, "R10 reset reqReady", int'(reqReady), 1);
    check(cmdValid == 1'b0, "R10 reset cmdValid", int'(cmdValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chkOn = 1'b1;
    repeat (2) @(negedge clk);

    doReq(0, 1, 0, 'h0100);   // R3, R4: miss, memory read, fill, singlet to core 1
    doReq(0, 3, 0, 'h0100);   // R2, R5: forward to core 1, core 1 no longer singlet
    doReq(0, 0, 0, 'h0100);   // R2: lowest other holder is core 1
    doReq(0, 2, 0, 'h0100);   // R2: now core 0 is lowest
    doReq(1, 0, 0, 'h0100);   // R6: removal, three holders remain
    doReq(1, 1, 0, 'h0100);   // R6
    doReq(1, 3, 0, 'h0100);   // R6, R4: only core 2 remains -> singlet
    curTag = 6;
    doReq(1, 0, 0, 'h0100);   // R6: non-holder, no effect
    doReq(1, 2, 0, 'h0999);   // R6: untracked block, no effect
    curTag = 0;
    doReq(2, 2, 1, 'h0100);   // R7: spill 2 -> 1, singlet moves to core 1
    doReq(0, 3, 0, 'h0100);   // R2: forward now comes from core 1
    doReq(1, 3, 0, 'h0100);   // R4 singlet back to core 1
    doReq(1, 1, 0, 'h0100);   // R8: holder set empty, entry released
    doReq(0, 0, 0, 'h0100);   // R8: read goes to memory, re-allocated

    curTag = 11;
    doReq(3, 1, 2, 'h0100);   // R11: no-op kind
    doReq(0, 2, 0, 'h0100);   // R11: holder set untouched, forward to core 0
    curTag = 3;
    fillValid = 1'b1;         // R3: stray fill while idle
    @(negedge clk);
    fillValid = 1'b0;
    repeat (3) @(negedge clk);
    curTag = 0;

    // R8: fill the table with 15 more blocks
    for (int i = 1; i < NE; i++) doReq(0, i % NC, 0, 'h2000 + i);
    curTag = 8;
    doReq(0, 2, 0, 'h3000);   // R8: table full, memory read, untracked, no notice
    doReq(0, 1, 0, 'h3000);   // R8: still untracked -> memory again
    doReq(1, 3, 0, 'h2003);   // R8: release one entry
    doReq(0, 1, 0, 'h3000);   // R8: now allocated, singlet to core 1
    doReq(0, 0, 0, 'h3000);   // R8: tracked, forward to core 1
    curTag = 7;
    doReq(2, 0, 3, 'h4000);   // R7: spill of untracked block, forward only
    doReq(2, 1, 2, 'h2005);   // R7: spill of tracked singlet 1 -> 2
    curTag = 0;
    doReq(0, 0, 0, 'h2005);   // R2, R5
    repeat (4) @(negedge clk);

    check(evq.size() == 0, "R10 pending commands", evq.size(), 0);
    finished = 1'b1;
    finish();
  end

endmodule